// File: doc/BRIEF.md
# Transmit Buffer Ownership Controller

This block arbitrates a single transmit buffer between two owners: the firmware, which fills the buffer and marks it ready, and the hardware sending engine, which drains it. The firmware sees one flag that says the buffer holds a frame waiting to go out. The hardware sees the same flag and may claim the buffer. While the hardware holds the claim, the firmware cannot change the ready flag.

The firmware uses single-cycle strobes to request that the ready flag be set or cleared, and a third strobe to acknowledge the end-of-transmit interrupt. The sending datapath is modelled only by a start pulse, a per-word sent pulse and an end-of-frame level. When the last word leaves while end-of-frame is high, the block drops the claim and the ready flag together, and raises a sticky end-of-transmit status. The ready flag is only ever raised by the firmware, and the hardware can only lower it.

All interfaces are plain strobes and levels. There is no data stream, so there is no back-pressure. Any request the block cannot honour in a given cycle is dropped, not held for later. Every output is a register and changes on the clock edge after the input that caused it.

Top module: `txbuf_own_ctrl`

## Requirements
- R1: After reset, `data_rdy`, `buf_lock` and `eot_status` are all 0.
- R2: A `hw_start` pulse while `data_rdy`=1 and `buf_lock`=0 sets `buf_lock` to 1 on the next edge. A `hw_start` pulse while `data_rdy`=0 leaves `buf_lock` at 0.
- R3: While `buf_lock`=1, a cycle with both `word_sent`=1 and `frame_end`=1 is an end-of-transmit. On the next edge it clears `buf_lock`, clears `data_rdy` and sets `eot_status`. While locked, `word_sent` without `frame_end`, or `frame_end` without `word_sent`, changes nothing.
- R4: A `fw_set_rdy` strobe while `buf_lock`=0 sets `data_rdy` to 1 on the next edge.
- R5: A `fw_clr_rdy` strobe while `buf_lock`=0 clears `data_rdy` on the next edge. If both strobes arrive in the same unlocked cycle, the clear wins.
- R6: While `buf_lock`=1, `fw_set_rdy` and `fw_clr_rdy` have no effect on `data_rdy`. They are dropped, not queued, so they also have no effect after the lock is released.
- R7: The hardware side never raises `data_rdy`. The only rise of `data_rdy` follows an unlocked `fw_set_rdy`.
- R8: `eot_status` stays 1 until a `fw_eot_clr` strobe clears it. If an end-of-transmit and `fw_eot_clr` fall in the same cycle, `eot_status` is 1 afterwards.
- R9: While `buf_lock`=0, `word_sent` and `frame_end` have no effect on any output.
- R10: When `hw_start` is accepted in the same cycle as a firmware set or clear strobe, the start wins. The lock is taken, the firmware strobe is dropped, and `data_rdy` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_set_rdy | input | 1 | Firmware strobe asking to raise the ready flag |
| fw_clr_rdy | input | 1 | Firmware strobe asking to lower the ready flag |
| fw_eot_clr | input | 1 | Firmware strobe acknowledging end-of-transmit |
| hw_start | input | 1 | Sending engine starts draining the buffer |
| word_sent | input | 1 | One word has left the buffer this cycle |
| frame_end | input | 1 | Level: the current word is the last of the frame |
| data_rdy | output | 1 | Buffer holds a frame ready to send |
| buf_lock | output | 1 | Hardware owns the buffer |
| eot_status | output | 1 | Sticky end-of-transmit interrupt status |

## Verification
Every piece of state is a single flag that drives a port, so a wrong internal value shows on the next clock edge. Expect a lock that never releases, or a ready flag that moves while locked. Another sign is a ready flag that survives an end-of-transmit, which leaves the firmware unable to refill the buffer. The subtle faults are about ordering: a dropped request that comes back after the unlock, or a clear that loses to a coincident set. These only show one cycle after the lock falls, or in the exact cycle where the two strobes collide. The directed scenarios aim at those cycles.

// File: rtl/txo_pkg.sv
package txo_pkg;

  typedef enum logic [0:0] {
    OWN_FW = 1'b0,
    OWN_HW = 1'b1
  } owner_e;

  typedef struct packed {
    logic start_acc;
    logic eot_evt;
    logic set_acc;
    logic clr_acc;
  } txo_evt_t;

endpackage

// File: rtl/txo_event_decode.sv
module txo_event_decode
  import txo_pkg::*;
(
  input  logic     fw_set_rdy,
  input  logic     fw_clr_rdy,
  input  logic     hw_start,
  input  logic     word_sent,
  input  logic     frame_end,
  input  logic     rdy_q,
  input  owner_e   owner_q,
  output txo_evt_t evt
);
  logic locked;
  logic fw_open;

  always_comb begin
    locked        = (owner_q == OWN_HW);
    evt.start_acc = hw_start & rdy_q & ~locked;
    evt.eot_evt   = locked & word_sent & frame_end;
    // firmware may touch the flag only when unlocked and no start is claiming it
    fw_open       = ~locked & ~evt.start_acc;
    evt.clr_acc   = fw_open & fw_clr_rdy;
    evt.set_acc   = fw_open & fw_set_rdy & ~fw_clr_rdy;
  end
endmodule

// File: rtl/txo_owner.sv
module txo_owner
  import txo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  txo_evt_t evt,
  output owner_e   owner_q
);
  owner_e owner_d;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_FW: if (evt.start_acc) owner_d = OWN_HW;
      OWN_HW: if (evt.eot_evt)   owner_d = OWN_FW;
      default: owner_d = OWN_FW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_FW;
    else        owner_q <= owner_d;
  end
endmodule

// File: rtl/txo_flag.sv
module txo_flag #(
  parameter bit SET_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic d;

  generate
    if (SET_WINS) begin : g_set_pri
      always_comb d = set_i ? 1'b1 : (clr_i ? 1'b0 : q);
    end else begin : g_clr_pri
      always_comb d = clr_i ? 1'b0 : (set_i ? 1'b1 : q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/txbuf_own_ctrl.sv
module txbuf_own_ctrl
  import txo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fw_set_rdy,
  input  logic fw_clr_rdy,
  input  logic fw_eot_clr,
  input  logic hw_start,
  input  logic word_sent,
  input  logic frame_end,
  output logic data_rdy,
  output logic buf_lock,
  output logic eot_status
);
  txo_evt_t evt;
  owner_e   owner_q;
  logic     rdy_q;
  logic     rdy_clr;

  txo_event_decode u_dec (
    .fw_set_rdy (fw_set_rdy),
    .fw_clr_rdy (fw_clr_rdy),
    .hw_start   (hw_start),
    .word_sent  (word_sent),
    .frame_end  (frame_end),
    .rdy_q      (rdy_q),
    .owner_q    (owner_q),
    .evt        (evt)
  );

  txo_owner u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .owner_q (owner_q)
  );

  // hardware may only lower the ready flag; firmware lowers it when unlocked
  assign rdy_clr = evt.eot_evt | evt.clr_acc;

  txo_flag #(.SET_WINS(1'b0)) u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt.set_acc),
    .clr_i (rdy_clr),
    .q     (rdy_q)
  );

  txo_flag #(.SET_WINS(1'b1)) u_eot (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt.eot_evt),
    .clr_i (fw_eot_clr),
    .q     (eot_status)
  );

  assign data_rdy = rdy_q;
  assign buf_lock = (owner_q == OWN_HW);
endmodule

// File: rtl/txbuf_own_ctrl_chk.sv
module txbuf_own_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic fw_set_rdy,
  input logic fw_clr_rdy,
  input logic fw_eot_clr,
  input logic hw_start,
  input logic word_sent,
  input logic frame_end,
  input logic data_rdy,
  input logic buf_lock,
  input logic eot_status
);
  a_r2_start_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_lock && data_rdy && hw_start) |=> buf_lock);

  a_r2_no_lock_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_lock) |-> data_rdy);

  a_r3_eot_release: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_lock && word_sent && frame_end) |=> (!buf_lock && !data_rdy && eot_status));

  a_r6_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_lock && !(word_sent && frame_end)) |=> ($stable(data_rdy) && buf_lock));

  a_r7_rise_by_fw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> ($past(fw_set_rdy) && !$past(fw_clr_rdy) && !$past(buf_lock)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_status && !fw_eot_clr) |=> eot_status);

  a_r9_idle_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_lock && !hw_start) |=> !buf_lock);

  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_lock && data_rdy && hw_start && fw_clr_rdy) |=> (buf_lock && data_rdy));
endmodule

bind txbuf_own_ctrl txbuf_own_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fw_set_rdy (fw_set_rdy),
  .fw_clr_rdy (fw_clr_rdy),
  .fw_eot_clr (fw_eot_clr),
  .hw_start   (hw_start),
  .word_sent  (word_sent),
  .frame_end  (frame_end),
  .data_rdy   (data_rdy),
  .buf_lock   (buf_lock),
  .eot_status (eot_status)
);

// File: tb/tb_txbuf_own_ctrl.sv
module tb_txbuf_own_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fw_set_rdy = 0, fw_clr_rdy = 0, fw_eot_clr = 0;
  logic hw_start = 0, word_sent = 0, frame_end = 0;
  logic data_rdy, buf_lock, eot_status;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbuf_own_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .fw_set_rdy(fw_set_rdy), .fw_clr_rdy(fw_clr_rdy), .fw_eot_clr(fw_eot_clr),
    .hw_start(hw_start), .word_sent(word_sent), .frame_end(frame_end),
    .data_rdy(data_rdy), .buf_lock(buf_lock), .eot_status(eot_status)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act{rdy,lock,eot}=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic idle_in();
    fw_set_rdy = 0; fw_clr_rdy = 0; fw_eot_clr = 0;
    hw_start = 0; word_sent = 0; frame_end = 0;
  endtask

  // inputs are held for one cycle, then released; outputs sampled at the next negedge
  task automatic step();
    @(negedge clk);
    idle_in();
  endtask

  function automatic logic [2:0] outs();
    return {data_rdy, buf_lock, eot_status};
  endfunction

  task automatic t_reset();
    chk("R1 reset", outs(), 3'b000);
  endtask

  task automatic t_fw_set_clr();
    fw_set_rdy = 1; step();
    chk("R4 fw set", outs(), 3'b100);
    fw_clr_rdy = 1; step();
    chk("R5 fw clear", outs(), 3'b000);
    fw_set_rdy = 1; step();
    fw_set_rdy = 1; fw_clr_rdy = 1; step();
    chk("R5 clear wins", outs(), 3'b000);
  endtask

  task automatic t_start_gate();
    hw_start = 1; step();
    chk("R2 start while empty", outs(), 3'b000);
    fw_set_rdy = 1; step();
    hw_start = 1; step();
    chk("R2 start locks", outs(), 3'b110);
  endtask

  task automatic t_locked_ignore();
    fw_clr_rdy = 1; step();
    chk("R6 clr ignored locked", outs(), 3'b110);
    word_sent = 1; step();
    chk("R3 word without end", outs(), 3'b110);
    frame_end = 1; step();
    chk("R3 end without word", outs(), 3'b110);
    fw_set_rdy = 1; step();
    word_sent = 1; frame_end = 1; step();
    chk("R3 eot release", outs(), 3'b001);
    step();
    chk("R6 not queued", outs(), 3'b001);
  endtask

  task automatic t_sticky();
    step(); step();
    chk("R8 sticky", outs(), 3'b001);
    fw_eot_clr = 1; step();
    chk("R8 fw clear", outs(), 3'b000);
    fw_set_rdy = 1; step();
    hw_start = 1; step();
    word_sent = 1; frame_end = 1; fw_eot_clr = 1; step();
    chk("R8 set wins over clear", outs(), 3'b001);
    chk("R7 hw cleared rdy", outs(), 3'b001);
    fw_eot_clr = 1; step();
  endtask

  task automatic t_stray_sent();
    word_sent = 1; frame_end = 1; step();
    chk("R9 stray unlocked empty", outs(), 3'b000);
    fw_set_rdy = 1; step();
    word_sent = 1; frame_end = 1; step();
    chk("R9 stray unlocked ready", outs(), 3'b100);
  endtask

  task automatic t_start_vs_fw();
    hw_start = 1; fw_clr_rdy = 1; step();
    chk("R10 start beats clear", outs(), 3'b110);
    word_sent = 1; frame_end = 1; step();
    fw_eot_clr = 1; fw_set_rdy = 1; step();
    chk("R7 refill after eot", outs(), 3'b100);
    hw_start = 1; fw_set_rdy = 1; step();
    chk("R10 start with set", outs(), 3'b110);
  endtask

  initial begin
    idle_in();
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_fw_set_clr();
    t_start_gate();
    t_locked_ignore();
    t_sticky();
    t_stray_sent();
    t_start_vs_fw();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule